// File: doc/BRIEF.md
# Bytecode Dispatch Unit with Skip Mask

This block speeds up the inner loop of an interpreter. On a start strobe it requests one byte from a shared memory over a request/valid port. It uses that byte as an index into a local 256-entry table and steers a simple instruction sequencer to the code address stored in the chosen entry. The rest of the entry is a skip mask. Bit 0 of the mask flags the first instruction at the target, bit 1 flags the next, and so on. A flagged instruction is passed over rather than executed.

The execution datapath sits outside the block. It moves the sequencer one instruction per `step_i` pulse, reads `pc_o`, and drops the instruction whenever `skip_o` is high. Software fills the table beforehand through a simple write port. With a memory that answers at once, a full dispatch takes six clocks from the start strobe to the jump taking effect. Each cycle the memory holds back its valid signal adds exactly one clock.

Top module: `bytecode_dispatch`

## Requirements
- R1: After synchronous reset, `pc_o`, `skip_o`, `done_o` and `mem_req_o` are all 0.
- R2: A start accepted while idle raises `mem_req_o` on the next cycle. `mem_req_o` stays high up to and including the cycle in which `mem_valid_i` is seen. Throughout, `mem_addr_o` holds the `code_addr_i` value sampled with the start.
- R3: The table has 256 entries of 32 bits. A write with `tbl_we_i` high stores `tbl_wdata_i` at index `tbl_waddr_i`. The byte fetched by a dispatch selects the entry that the dispatch uses.
- R4: Bits 8:0 of the entry are the jump target. At commit, `pc_o` becomes that target.
- R5: Bits 31:9 of the entry are the skip mask. `skip_o` always shows bit 0 of the current mask, so the first instruction at the target is governed by entry bit 9.
- R6: While idle, each cycle with `step_i` high increments `pc_o` by one and shifts the mask right by one. Once the mask reaches zero, `skip_o` stays 0 until the next commit.
- R7: With no memory stall, `done_o` and the new `pc_o` appear six rising edges after the edge that samples the start.
- R8: Each cycle in which the memory withholds `mem_valid_i` after the request delays the commit by exactly one cycle.
- R9: A start strobe seen while a dispatch is in progress is ignored. It causes no extra request and no extra `done_o`.
- R10: `done_o` is a one-cycle pulse in the cycle the jump is committed.
- R11: While a dispatch is in progress, `step_i` has no effect on `pc_o` or the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a dispatch (ignored while busy) |
| code_addr_i | input | ADDR_BITS | Shared-memory address of the bytecode |
| step_i | input | 1 | Advance the sequencer by one instruction |
| mem_req_o | output | 1 | Byte request to shared memory |
| mem_addr_o | output | ADDR_BITS | Address of the requested byte |
| mem_valid_i | input | 1 | Shared memory returns the byte this cycle |
| mem_byte_i | input | 8 | Returned byte |
| tbl_we_i | input | 1 | Table write enable |
| tbl_waddr_i | input | 8 | Table entry index to write |
| tbl_wdata_i | input | 32 | Entry: bits 31:9 skip mask, bits 8:0 target |
| pc_o | output | 9 | Sequencer program counter |
| skip_o | output | 1 | Current instruction is to be passed over |
| done_o | output | 1 | One-cycle pulse when the jump commits |

## Verification
The embedded properties check several things on every cycle. They check that the fetch address is held while a request is outstanding. They check that a withheld valid keeps the controller waiting. They check that a busy controller never re-enters the request state and that `done_o` never lasts two cycles. They check that the stall-free part of a dispatch spans exactly six cycles. They check that the sequencer holds while busy and advances by one with a halved mask otherwise.

Some behaviour only the bench scenarios can show. These are end-to-end properties: the right table entry is selected by the fetched byte, the skip pattern seen across a run of steps matches the stored mask, and a rewritten entry takes effect. The bench compares against a behavioural model every clock.

// File: rtl/disp_pkg.sv
`timescale 1ns/1ps
package disp_pkg;

    localparam int ADDR_W   = 19;
    localparam int TGT_W    = 9;
    localparam int SKIP_W   = 23;
    localparam int IDX_W    = 8;
    localparam int ENTRY_W  = TGT_W + SKIP_W;
    localparam int ENTRIES  = 1 << IDX_W;
    localparam int LAT_W    = 3;
    // stall-free cycles spent before the commit state
    localparam int PRE_COMMIT = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_INDEX,
        ST_LOOKUP,
        ST_SPLIT,
        ST_COMMIT
    } disp_state_e;

    typedef struct packed {
        logic [SKIP_W-1:0] skip;
        logic [TGT_W-1:0]  target;
    } lut_entry_t;

    typedef struct packed {
        logic [TGT_W-1:0]  target;
        logic [SKIP_W-1:0] mask;
    } jump_t;

    function automatic jump_t entry_to_jump(input logic [ENTRY_W-1:0] raw);
        lut_entry_t e;
        jump_t      j;
        e        = lut_entry_t'(raw);
        j.target = e.target;
        j.mask   = e.skip;
        return j;
    endfunction

    function automatic logic [SKIP_W-1:0] shift_mask(input logic [SKIP_W-1:0] m);
        return m >> 1;
    endfunction

    function automatic logic is_fetching(input disp_state_e s);
        return (s == ST_ISSUE) || (s == ST_WAIT);
    endfunction

endpackage

// File: rtl/disp_lut.sv
`timescale 1ns/1ps
module disp_lut
    import disp_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en_i,
    input  logic [IDX_W-1:0]   wr_idx_i,
    input  logic [ENTRY_W-1:0] wr_data_i,
    input  logic               rd_req_i,
    input  logic [IDX_W-1:0]   rd_idx_i,
    output logic [ENTRY_W-1:0] rdata_o
);

    logic [ENTRY_W-1:0] mem_q [ENTRIES];
    logic [IDX_W-1:0]   idx_q;
    logic               pend_q;
    logic [ENTRY_W-1:0] rdata_q;

    // write port: one entry per cycle
    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            mem_q[wr_idx_i] <= wr_data_i;
        end
    end

    // stage 1: register the index
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            idx_q  <= '0;
        end else begin
            pend_q <= rd_req_i;
            if (rd_req_i) begin
                idx_q <= rd_idx_i;
            end
        end
    end

    // stage 2: array read into an output register
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (pend_q) begin
            rdata_q <= mem_q[idx_q];
        end
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/disp_ctrl.sv
`timescale 1ns/1ps
module disp_ctrl
    import disp_pkg::*;
#(
    parameter int ADDR_BITS = ADDR_W
)(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_i,
    input  logic [ADDR_BITS-1:0] code_addr_i,
    input  logic                 mem_valid_i,
    input  logic [IDX_W-1:0]     mem_byte_i,
    output logic                 mem_req_o,
    output logic [ADDR_BITS-1:0] mem_addr_o,
    output logic                 lut_req_o,
    output logic [IDX_W-1:0]     lut_idx_o,
    input  logic [ENTRY_W-1:0]   lut_rdata_i,
    output jump_t                jump_o,
    output logic                 load_o,
    output logic                 busy_o,
    output logic                 done_o
);

    disp_state_e           state_q, state_d;
    logic [ADDR_BITS-1:0]  addr_q;
    logic [IDX_W-1:0]      byte_q;
    jump_t                 jump_q;
    logic                  done_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i)     state_d = ST_ISSUE;
            ST_ISSUE:                   state_d = ST_WAIT;
            ST_WAIT:   if (mem_valid_i) state_d = ST_INDEX;
            ST_INDEX:                   state_d = ST_LOOKUP;
            ST_LOOKUP:                  state_d = ST_SPLIT;
            ST_SPLIT:                   state_d = ST_COMMIT;
            ST_COMMIT:                  state_d = ST_IDLE;
            default:                    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            byte_q  <= '0;
            jump_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == ST_COMMIT);
            if (state_q == ST_IDLE && start_i) begin
                addr_q <= code_addr_i;
            end
            if (state_q == ST_WAIT && mem_valid_i) begin
                byte_q <= mem_byte_i;
            end
            if (state_q == ST_SPLIT) begin
                jump_q <= entry_to_jump(lut_rdata_i);
            end
        end
    end

    assign mem_req_o  = is_fetching(state_q);
    assign mem_addr_o = addr_q;
    assign lut_req_o  = (state_q == ST_INDEX);
    assign lut_idx_o  = byte_q;
    assign jump_o     = jump_q;
    assign load_o     = (state_q == ST_COMMIT);
    assign busy_o     = (state_q != ST_IDLE);
    assign done_o     = done_q;

    // stall-free cycle counter for the latency check
    logic [LAT_W-1:0] lat_cnt_q;
    always_ff @(posedge clk) begin
        if (rst || state_q == ST_IDLE) begin
            lat_cnt_q <= '0;
        end else if (!(state_q == ST_WAIT && !mem_valid_i)) begin
            lat_cnt_q <= lat_cnt_q + 1'b1;
        end
    end

    // R9
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |=> (state_q != ST_ISSUE));

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT && !mem_valid_i) |=> (state_q == ST_WAIT && $stable(mem_addr_o)));

    // R2
    req_addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && !(state_q == ST_WAIT && mem_valid_i)) |=> (mem_req_o && $stable(mem_addr_o)));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R7
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_COMMIT) |-> (lat_cnt_q == LAT_W'(PRE_COMMIT)));

endmodule

// File: rtl/disp_seq.sv
`timescale 1ns/1ps
module disp_seq
    import disp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             step_i,
    input  logic             hold_i,
    input  logic             load_i,
    input  jump_t            jump_i,
    output logic [TGT_W-1:0] pc_o,
    output logic             skip_o
);

    logic [TGT_W-1:0]  pc_q;
    logic [SKIP_W-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= '0;
            mask_q <= '0;
        end else if (load_i) begin
            pc_q   <= jump_i.target;
            mask_q <= jump_i.mask;
        end else if (step_i && !hold_i) begin
            pc_q   <= pc_q + 1'b1;
            mask_q <= shift_mask(mask_q);
        end
    end

    assign pc_o   = pc_q;
    assign skip_o = mask_q[0];

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (hold_i && !load_i) |=> ($stable(pc_q) && $stable(mask_q)));

    // R6
    advance_chk: assert property (@(posedge clk) disable iff (rst)
        (step_i && !hold_i && !load_i) |=>
            (pc_q == $past(pc_q) + 1'b1 && mask_q == ($past(mask_q) >> 1)));

    // R4
    load_target_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (pc_q == $past(jump_i.target)));

endmodule

// File: rtl/bytecode_dispatch.sv
`timescale 1ns/1ps
module bytecode_dispatch
    import disp_pkg::*;
#(
    parameter int ADDR_BITS = ADDR_W
)(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_i,
    input  logic [ADDR_BITS-1:0] code_addr_i,
    input  logic                 step_i,
    output logic                 mem_req_o,
    output logic [ADDR_BITS-1:0] mem_addr_o,
    input  logic                 mem_valid_i,
    input  logic [IDX_W-1:0]     mem_byte_i,
    input  logic                 tbl_we_i,
    input  logic [IDX_W-1:0]     tbl_waddr_i,
    input  logic [ENTRY_W-1:0]   tbl_wdata_i,
    output logic [TGT_W-1:0]     pc_o,
    output logic                 skip_o,
    output logic                 done_o
);

    logic               lut_req;
    logic [IDX_W-1:0]   lut_idx;
    logic [ENTRY_W-1:0] lut_rdata;
    jump_t              jump;
    logic               load;
    logic               busy;

    disp_ctrl #(.ADDR_BITS(ADDR_BITS)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .code_addr_i (code_addr_i),
        .mem_valid_i (mem_valid_i),
        .mem_byte_i  (mem_byte_i),
        .mem_req_o   (mem_req_o),
        .mem_addr_o  (mem_addr_o),
        .lut_req_o   (lut_req),
        .lut_idx_o   (lut_idx),
        .lut_rdata_i (lut_rdata),
        .jump_o      (jump),
        .load_o      (load),
        .busy_o      (busy),
        .done_o      (done_o)
    );

    disp_lut u_lut (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (tbl_we_i),
        .wr_idx_i  (tbl_waddr_i),
        .wr_data_i (tbl_wdata_i),
        .rd_req_i  (lut_req),
        .rd_idx_i  (lut_idx),
        .rdata_o   (lut_rdata)
    );

    disp_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .step_i (step_i),
        .hold_i (busy),
        .load_i (load),
        .jump_i (jump),
        .pc_o   (pc_o),
        .skip_o (skip_o)
    );

endmodule

// File: tb/test_bytecode_dispatch.sv
`timescale 1ns/1ps
module test_bytecode_dispatch;
    import disp_pkg::*;

    localparam int AB = ADDR_W;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                start = 1'b0;
    logic [AB-1:0]       code_addr = '0;
    logic                step = 1'b0;
    logic                mem_req;
    logic [AB-1:0]       mem_addr;
    logic                mem_valid = 1'b0;
    logic [IDX_W-1:0]    mem_byte = '0;
    logic                tbl_we = 1'b0;
    logic [IDX_W-1:0]    tbl_waddr = '0;
    logic [ENTRY_W-1:0]  tbl_wdata = '0;
    logic [TGT_W-1:0]    pc_o;
    logic                skip_o;
    logic                done_o;

    always #2.5 clk = ~clk;

    bytecode_dispatch #(.ADDR_BITS(AB)) i_bytecode_dispatch (
        .clk(clk), .rst(rst), .start_i(start), .code_addr_i(code_addr), .step_i(step),
        .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_valid_i(mem_valid), .mem_byte_i(mem_byte),
        .tbl_we_i(tbl_we), .tbl_waddr_i(tbl_waddr), .tbl_wdata_i(tbl_wdata),
        .pc_o(pc_o), .skip_o(skip_o), .done_o(done_o)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    bit cmp_on = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // table image kept by the bench
    logic [ENTRY_W-1:0] tbl_img [ENTRIES];

    function automatic logic [ENTRY_W-1:0] ent(input int i);
        logic [ENTRY_W-1:0] r;
        r[TGT_W-1:0] = TGT_W'(i * 13 + 7);
        r[ENTRY_W-1:TGT_W] = SKIP_W'((i * 40503) ^ 32'h1B5F3);
        if (i == 255) r[ENTRY_W-1:TGT_W] = '1;
        if (i == 0)   r[ENTRY_W-1:TGT_W] = '0;
        return r;
    endfunction

    function automatic logic [7:0] byte_at(input logic [AB-1:0] a);
        return a[7:0] ^ 8'h5A;
    endfunction

    function automatic logic [AB-1:0] addr_for(input logic [7:0] b, input int hi);
        return {AB'(hi) << 8} | AB'(b ^ 8'h5A);
    endfunction

    // shared memory model
    int stall_len = 0;
    int req_cnt = 0;
    always @(posedge clk) begin
        if (rst || !mem_req) req_cnt <= 0;
        else                 req_cnt <= req_cnt + 1;
    end
    always @(negedge clk) begin
        mem_valid = mem_req && (req_cnt >= 1 + stall_len);
        mem_byte  = byte_at(mem_addr);
    end

    // behavioural reference model
    int               m_phase = 0;
    int               m_cnt = 0;
    logic [TGT_W-1:0] m_pc = '0;
    logic [SKIP_W-1:0] m_mask = '0;
    logic             m_done = 0;
    logic [AB-1:0]    m_addr = '0;
    logic [7:0]       m_byte = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_phase = 0; m_cnt = 0; m_pc = '0; m_mask = '0; m_done = 0; m_addr = '0;
        end else begin
            m_done = 0;
            case (m_phase)
                0: begin
                    if (step) begin m_pc = m_pc + 1'b1; m_mask = m_mask >> 1; end
                    if (start) begin m_phase = 1; m_addr = code_addr; end
                end
                1: m_phase = 2;
                2: if (mem_valid) begin m_byte = byte_at(m_addr); m_phase = 3; m_cnt = 4; end
                default: begin
                    if (m_cnt == 1) begin
                        m_pc    = tbl_img[m_byte][TGT_W-1:0];
                        m_mask  = tbl_img[m_byte][ENTRY_W-1:TGT_W];
                        m_done  = 1;
                        m_phase = 0;
                    end else begin
                        m_cnt = m_cnt - 1;
                    end
                end
            endcase
        end
    end

    // per-cycle comparison
    always @(negedge clk) begin
        if (cmp_on) begin
            chk(pc_o == m_pc, "R4/R6", "pc", pc_o, m_pc);
            chk(skip_o == m_mask[0], "R5", "skip", skip_o, m_mask[0]);
            chk(done_o == m_done, "R10", "done", done_o, m_done);
            chk(mem_req == (m_phase == 1 || m_phase == 2), "R2", "mem_req", mem_req, (m_phase == 1 || m_phase == 2));
            if (mem_req) chk(mem_addr == m_addr, "R2", "mem_addr", mem_addr, m_addr);
        end
    end

    task automatic load_table();
        for (int i = 0; i < ENTRIES; i++) begin
            tbl_we = 1; tbl_waddr = IDX_W'(i); tbl_wdata = ent(i); tbl_img[i] = ent(i);
            @(negedge clk);
        end
        tbl_we = 0;
    endtask

    task automatic dispatch(input logic [AB-1:0] a, input int stall, input bit keep_start,
                            input bit keep_step, output int lat, output int dones);
        logic [7:0] b;
        b = byte_at(a);
        stall_len = stall; code_addr = a; start = 1; step = keep_step;
        lat = 0; dones = 0;
        for (int n = 1; n <= 60; n++) begin
            @(negedge clk);
            if (!(keep_start && n < 4)) start = 0;
            if (done_o) begin
                dones++;
                if (lat == 0) begin
                    lat = n;
                    chk(pc_o == tbl_img[b][TGT_W-1:0], "R4", "target pc", pc_o, tbl_img[b][TGT_W-1:0]);
                    chk(skip_o == tbl_img[b][TGT_W], "R5", "first skip", skip_o, tbl_img[b][TGT_W]);
                end
            end
            if (lat != 0 && n >= lat + 6) break;
        end
        start = 0; step = 0;
    endtask

    initial begin
        int lat, dones, skips;
        logic [TGT_W-1:0] pc0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(pc_o == 0, "R1", "pc after reset", pc_o, 0);
        chk(skip_o == 0, "R1", "skip after reset", skip_o, 0);
        chk(done_o == 0, "R1", "done after reset", done_o, 0);
        chk(mem_req == 0, "R1", "mem_req after reset", mem_req, 0);
        cmp_on = 1;

        load_table();   // R3

        // R7 no stall
        dispatch(addr_for(8'h11, 3), 0, 0, 0, lat, dones);
        chk(lat == 7, "R7", "latency no stall", lat, 7);
        chk(dones == 1, "R10", "done count", dones, 1);
        for (int k = 0; k < 12; k++) begin step = k[0]; @(negedge clk); end
        step = 0;

        // R8 stall of 3, all-ones mask
        dispatch(addr_for(8'hFF, 100), 3, 0, 0, lat, dones);
        chk(lat == 10, "R8", "latency stall 3", lat, 10);
        skips = 0;
        for (int k = 0; k < 30; k++) begin
            if (skip_o) skips++;
            step = 1;
            @(negedge clk);
        end
        step = 0;
        chk(skips == 23, "R6", "skipped slots for full mask", skips, 23);
        chk(skip_o == 0, "R6", "skip after mask drained", skip_o, 0);

        // R9 start held while busy, R11 step held while busy
        dispatch(addr_for(8'h00, 7), 0, 1, 1, lat, dones);
        chk(dones == 1, "R9", "done pulses with busy start", dones, 1);
        chk(lat == 7, "R11", "latency with step held", lat, 7);

        // R3 rewritten entry takes effect
        tbl_we = 1; tbl_waddr = 8'h42; tbl_wdata = {23'h000005, 9'h1A3}; tbl_img[8'h42] = {23'h000005, 9'h1A3};
        @(negedge clk);
        tbl_we = 0;
        dispatch(addr_for(8'h42, 9), 0, 0, 0, lat, dones);
        pc0 = pc_o;
        chk(pc0 == 9'h1A3, "R3", "rewritten target", pc0, 9'h1A3);
        chk(skip_o == 1, "R3", "rewritten mask bit0", skip_o, 1);
        for (int k = 0; k < 6; k++) begin step = 1; @(negedge clk); end
        step = 0;

        // R8 longer stall
        dispatch(addr_for(8'h7C, 2), 7, 0, 0, lat, dones);
        chk(lat == 14, "R8", "latency stall 7", lat, 14);

        repeat (4) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog R7 actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule